// File: doc/BRIEF.md
# Fracturable LUT Logic Slice

This block is one logic slice of a small reconfigurable fabric. It holds four lookup elements, and each one stores a 32-entry truth table. Each element runs in one of two modes. In split mode it is two independent 4-input functions. In cascade mode the upper 4-input function feeds the address of the lower one, so the element computes a wider function of up to seven inputs. Two wide-function multiplexers can merge element results under a 2-bit select. A four-stage ripple carry path can turn the slice into an adder for two 4-bit operands, one addition per clock.

All eight slice results are available combinationally and also through a bank of eight registers. Each register has its own reset value, set by the configuration.

The configuration is a 143-bit serial stream. It is shifted in on a separate configuration clock and can only be loaded while the configuration enable is high. Data flows through the slice in a single cycle, with no back-pressure. For that reason every port is a plain level signal and no valid/ready handshake is used.

Top module: `fslice_top`

## Requirements
- R1: The configuration shifts in MSB first on the rising edge of `cfg_clk`, one bit per edge, only while `cfg_en` is high. When all 143 bits have been shifted in, the register holds the following fields, listed from MSB to LSB:
  - reset vector [142:135]
  - carry enable [134]
  - wide-mux-B enable [133]
  - wide-mux-A enable [132]
  - For each element k from 3 down to 0: the split bit at [33k+32] and the truth table at [33k+31:33k].
- R2: Each element k reads its input byte `lut_in[8k+7:8k]`. The upper result of element k is truth-table bit `16 + lut_in[8k+7:8k+4]`.
- R3: When the split bit of element k is 1, its main result is truth-table bit `lut_in[8k+3:8k]`.
- R4: When the split bit of element k is 0 (cascade mode), its main result is the truth-table bit addressed by {upper result, `lut_in[8k+2:8k]`}. In this mode, input bit `8k+3` has no effect.
- R5: With the carry path and both wide muxes disabled, the outputs are `comb_out[2k]` = main result of element k and `comb_out[2k+1]` = upper result of element k.
- R6: When wide-mux-A is enabled and the carry path is off, `comb_out[2]` shows main1 if `ho_sel[0]`=1 and main0 otherwise.
- R7: When wide-mux-B is enabled and the carry path is off, `comb_out[6]` depends on `ho_sel[1]`:
  - If `ho_sel[1]`=1, it is main3 when `ho_sel[0]`=1 and main2 otherwise.
  - If `ho_sel[1]`=0, it is the wide-mux-A value. That value is main0 when wide-mux-A is disabled.
- R8: When the carry enable is 1, stage k takes the upper result of element k as propagate and the main result as generate. `comb_out[2k]` becomes propagate XOR carry(k), with carry(0) = `carry_in`. The next carry is carry(k) when propagate is 1 and generate when propagate is 0. `carry_out` is carry(4). When the carry enable is 0, `carry_out` is 0. The carry path overrides both wide muxes.
- R9: When `reg_ce` is high at a rising edge of `clk`, `reg_out` takes `comb_out`. When `reg_ce` is low, `reg_out` holds its value.
- R10: When `rst` is high at a rising edge of `clk`, bit i of `reg_out` takes bit i of the reset vector. Reset wins over `reg_ce`.
- R11: With truth tables 16'h6666 (upper) and 16'h8888 (lower), split mode, and the carry path on, the slice adds two operands a and b. Element k receives a[k] on input 0 and b[k] on input 1 of both halves. The result is {`carry_out`, `comb_out[6]`, `comb_out[4]`, `comb_out[2]`, `comb_out[0]`} = a + b + `carry_in`, produced in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock for the output registers |
| rst | input | 1 | Synchronous active-high reset of the output registers |
| cfg_clk | input | 1 | Configuration shift clock |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_din | input | 1 | Serial configuration bit |
| lut_in | input | 32 | Element inputs, one byte per element |
| carry_in | input | 1 | Carry into stage 0 |
| reg_ce | input | 1 | Output register load enable |
| ho_sel | input | 2 | Wide-mux selects {B, A} |
| comb_out | output | 8 | Combinational slice results |
| reg_out | output | 8 | Registered slice results |
| carry_out | output | 1 | Carry out of stage 3 |

## Verification
The bench builds the slice with its default parameters: four elements, 32-entry truth tables, and a 143-bit configuration. At this size the bench can shift in a full stream per scenario. It can also sweep all four wide-mux select combinations and ripple a carry through all four stages, for example 15 + 1 and 15 + 15 + 1. The bench also covers:
- cascade and split modes, with the cascade-ignored input toggled;
- a reset vector with mixed bits;
- loads and holds under `reg_ce`;
- cycling `cfg_clk` with the enable low.

// File: rtl/fslice_pkg.sv
package fslice_pkg;
  localparam int NLUT    = 4;
  localparam int TT_W    = 32;
  localparam int IN_W    = 8;
  localparam int HALF_IN = 4;
  localparam int NOUT    = 2 * NLUT;
  localparam int SLOT_W  = TT_W + 1;
  localparam int CFG_W   = NOUT + 3 + NLUT * SLOT_W;
  localparam int MUXA_B  = NLUT * SLOT_W;
  localparam int MUXB_B  = MUXA_B + 1;
  localparam int CC_B    = MUXA_B + 2;
  localparam int RV_B    = MUXA_B + 3;
endpackage

// File: rtl/fslice_cfg.sv
module fslice_cfg #(
  parameter int W = fslice_pkg::CFG_W
) (
  input  logic         cfg_clk,
  input  logic         cfg_en,
  input  logic         cfg_din,
  output logic [W-1:0] bits
);
  // MSB-first shift: first bit entered ends at bit W-1
  always_ff @(posedge cfg_clk) begin
    if (cfg_en) bits <= {bits[W-2:0], cfg_din};
  end
endmodule

// File: rtl/fslice_lut.sv
module fslice_lut #(
  parameter int TT_W = fslice_pkg::TT_W,
  parameter int IN_W = fslice_pkg::IN_W
) (
  input  logic [TT_W-1:0] tt,
  input  logic            split,
  input  logic [IN_W-1:0] lin,
  output logic            upper,
  output logic            main
);
  localparam int HW = IN_W / 2;
  localparam int AW = $clog2(TT_W);

  logic [HW-1:0] lo_addr;

  always_comb begin
    upper = tt[{1'b1, lin[IN_W-1:HW]}];
    if (split) lo_addr = lin[HW-1:0];
    else       lo_addr = {upper, lin[HW-2:0]};
    main = tt[{{(AW-HW){1'b0}}, lo_addr}];
  end
endmodule

// File: rtl/fslice_carry.sv
module fslice_carry #(
  parameter int N = fslice_pkg::NLUT
) (
  input  logic [N-1:0] prop,
  input  logic [N-1:0] gen,
  input  logic         cin,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N:0] c;
  assign c[0] = cin;

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign sum[k]   = prop[k] ^ c[k];
    assign c[k+1]   = prop[k] ? c[k] : gen[k];
  end

  assign cout = c[N];
endmodule

// File: rtl/fslice_top.sv
module fslice_top
  import fslice_pkg::*;
#(
  parameter int N_LUT = NLUT,
  parameter int TBL_W = TT_W,
  parameter int LIN_W = IN_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cfg_clk,
  input  logic                   cfg_en,
  input  logic                   cfg_din,
  input  logic [N_LUT*LIN_W-1:0] lut_in,
  input  logic                   carry_in,
  input  logic                   reg_ce,
  input  logic [1:0]             ho_sel,
  output logic [2*N_LUT-1:0]     comb_out,
  output logic [2*N_LUT-1:0]     reg_out,
  output logic                   carry_out
);
  localparam int SW     = TBL_W + 1;
  localparam int NO     = 2 * N_LUT;
  localparam int BASE   = N_LUT * SW;
  localparam int TOTAL  = BASE + 3 + NO;

  logic [TOTAL-1:0] cfg_bits;
  logic [N_LUT-1:0] up_res, main_res, sum_res;
  logic             chain_co;
  logic             f7_on, f8_on, cc_on;
  logic [NO-1:0]    rst_vec;
  logic             muxa_v, muxb_v;

  fslice_cfg #(.W(TOTAL)) u_cfg (
    .cfg_clk (cfg_clk),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .bits    (cfg_bits)
  );

  assign f7_on   = cfg_bits[BASE];
  assign f8_on   = cfg_bits[BASE+1];
  assign cc_on   = cfg_bits[BASE+2];
  assign rst_vec = cfg_bits[BASE+3 +: NO];

  for (genvar k = 0; k < N_LUT; k++) begin : g_lut
    fslice_lut #(.TT_W(TBL_W), .IN_W(LIN_W)) u_lut (
      .tt    (cfg_bits[k*SW +: TBL_W]),
      .split (cfg_bits[k*SW + TBL_W]),
      .lin   (lut_in[k*LIN_W +: LIN_W]),
      .upper (up_res[k]),
      .main  (main_res[k])
    );
  end

  fslice_carry #(.N(N_LUT)) u_carry (
    .prop (up_res),
    .gen  (main_res),
    .cin  (carry_in),
    .sum  (sum_res),
    .cout (chain_co)
  );

  // wide muxes: A over elements 0/1, B over A-result and elements 2/3
  assign muxa_v = (f7_on && ho_sel[0]) ? main_res[1] : main_res[0];
  assign muxb_v = (f8_on && ho_sel[1]) ? (ho_sel[0] ? main_res[3] : main_res[2])
                                       : muxa_v;

  always_comb begin
    for (int k = 0; k < N_LUT; k++) begin
      comb_out[2*k]   = cc_on ? sum_res[k] : main_res[k];
      comb_out[2*k+1] = up_res[k];
    end
    if (!cc_on) begin
      if (f7_on) comb_out[2] = muxa_v;
      if (f8_on) comb_out[6] = muxb_v;
    end
  end

  assign carry_out = cc_on & chain_co;

  always_ff @(posedge clk) begin
    if (rst)         reg_out <= rst_vec;
    else if (reg_ce) reg_out <= comb_out;
  end
endmodule

// File: rtl/fslice_chk.sv
module fslice_chk #(
  parameter int NO = 8,
  parameter int CW = 143,
  parameter int NL = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_clk,
  input logic          cfg_en,
  input logic          reg_ce,
  input logic [NO-1:0] comb_out,
  input logic [NO-1:0] reg_out,
  input logic          carry_out,
  input logic [CW-1:0] cfg_bits,
  input logic          cc_on,
  input logic          f7_on,
  input logic [NL-1:0] main_res
);
  p_load_r9: assert property (@(posedge clk) disable iff (rst)
    reg_ce |=> reg_out == $past(comb_out));

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !reg_ce |=> $stable(reg_out));

  p_co_off_r8: assert property (@(posedge clk) disable iff (rst)
    !cc_on |-> !carry_out);

  p_slot2_r5: assert property (@(posedge clk) disable iff (rst)
    (!cc_on && !f7_on) |-> comb_out[2] == main_res[1]);

  p_cfg_frozen_r1: assert property (@(posedge cfg_clk) disable iff (rst)
    !cfg_en |=> $stable(cfg_bits));
endmodule

bind fslice_top fslice_chk #(.NO(2*N_LUT), .CW(TOTAL), .NL(N_LUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_clk   (cfg_clk),
  .cfg_en    (cfg_en),
  .reg_ce    (reg_ce),
  .comb_out  (comb_out),
  .reg_out   (reg_out),
  .carry_out (carry_out),
  .cfg_bits  (cfg_bits),
  .cc_on     (cc_on),
  .f7_on     (f7_on),
  .main_res  (main_res)
);

// File: tb/sim_fslice_top.sv
`timescale 1ns/1ps
module sim_fslice_top;
  logic        clk = 0, rst = 0, cfg_clk = 0, cfg_en = 0, cfg_din = 0;
  logic [31:0] lut_in = 0;
  logic        carry_in = 0, reg_ce = 0;
  logic [1:0]  ho_sel = 0;
  logic [7:0]  comb_out, reg_out;
  logic        carry_out;

  fslice_top u0 (.*);

  always #5 clk = ~clk;

  typedef struct {
    logic [7:0] c; logic co; logic [7:0] r;
    logic add_chk; logic [4:0] add_exp; string tag;
  } item_t;
  item_t q[$];

  int n_run = 0, n_fail = 0;

  // bench copy of the configuration fields
  logic [31:0] t [4];
  logic [3:0]  s;
  logic        m7, m8, cc;
  logic [7:0]  rv;
  logic [7:0]  exp_reg = 0, prev_comb = 0;
  logic        prev_ce = 0, rst_pend = 0;

  function automatic void model(input logic [31:0] li, input logic [1:0] hs,
                                input logic ci, output logic [7:0] o, output logic co);
    logic [3:0] up, mn;
    logic c, av;
    for (int k = 0; k < 4; k++) begin
      logic [3:0] ua, la;
      ua = li[8*k+4 +: 4];
      la = li[8*k +: 4];
      up[k] = t[k][16 + int'(ua)];
      if (!s[k]) la[3] = up[k];
      mn[k] = t[k][la];
      o[2*k] = mn[k];
      o[2*k+1] = up[k];
    end
    co = 0;
    if (cc) begin
      c = ci;
      for (int k = 0; k < 4; k++) begin
        o[2*k] = up[k] ^ c;
        c = up[k] ? c : mn[k];
      end
      co = c;
    end else begin
      av = (m7 && hs[0]) ? mn[1] : mn[0];
      if (m7) o[2] = av;
      if (m8) o[6] = hs[1] ? (hs[0] ? mn[3] : mn[2]) : av;
    end
  endfunction

  task automatic settle_regs();
    if (rst_pend) begin exp_reg = rv; rst_pend = 0; rst = 0; end
    else if (prev_ce) exp_reg = prev_comb;
  endtask

  task automatic load_cfg(input logic en);
    logic [142:0] b;
    @(posedge clk); #1;
    settle_regs();
    reg_ce = 0; prev_ce = 0;
    b = {rv, cc, m8, m7, s[3], t[3], s[2], t[2], s[1], t[1], s[0], t[0]};
    cfg_en = en;
    for (int i = 142; i >= 0; i--) begin
      cfg_din = en ? b[i] : ~b[i];
      #2 cfg_clk = 1;
      #2 cfg_clk = 0;
    end
    cfg_en = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    settle_regs();
    rst = 1; reg_ce = 1; prev_ce = 0; rst_pend = 1;
  endtask

  task automatic drive(input logic [31:0] li, input logic [1:0] hs, input logic ci,
                       input logic ce, input string tag,
                       input logic ac = 0, input logic [4:0] ae = 0);
    item_t it;
    logic [7:0] o; logic co;
    @(posedge clk); #1;
    settle_regs();
    lut_in = li; ho_sel = hs; carry_in = ci; reg_ce = ce;
    model(li, hs, ci, o, co);
    it.c = o; it.co = co; it.r = exp_reg; it.tag = tag;
    it.add_chk = ac; it.add_exp = ae;
    q.push_back(it);
    prev_ce = ce; prev_comb = o;
  endtask

  // monitor / scoreboard
  initial forever begin
    @(negedge clk);
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      n_run++;
      if (comb_out !== it.c || carry_out !== it.co || reg_out !== it.r) begin
        n_fail++;
        $display("FAIL %s: comb=%h co=%b reg=%h expected comb=%h co=%b reg=%h",
                 it.tag, comb_out, carry_out, reg_out, it.c, it.co, it.r);
      end
      if (it.add_chk) begin
        n_run++;
        if ({carry_out, comb_out[6], comb_out[4], comb_out[2], comb_out[0]} !== it.add_exp) begin
          n_fail++;
          $display("FAIL R11: sum=%b expected %b",
                   {carry_out, comb_out[6], comb_out[4], comb_out[2], comb_out[0]}, it.add_exp);
        end
      end
    end
  end

  function automatic logic [31:0] add_in(input logic [3:0] a, input logic [3:0] b);
    logic [31:0] v = 0;
    for (int k = 0; k < 4; k++) begin
      v[8*k]   = a[k]; v[8*k+1] = b[k];
      v[8*k+4] = a[k]; v[8*k+5] = b[k];
    end
    return v;
  endfunction

  initial begin
    #1_000_000;
    n_fail++; n_run++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // split mode, all muxes off (R1, R2, R3, R5, R10)
    t[0] = 32'hC3A5_96F0; t[1] = 32'h1234_ABCD; t[2] = 32'hF00F_5AA5; t[3] = 32'h8001_7EE7;
    s = 4'hF; m7 = 0; m8 = 0; cc = 0; rv = 8'hA5;
    load_cfg(1);
    do_reset();
    drive(32'h0000_0000, 2'b00, 0, 0, "R10 reset vector");
    drive(32'h0F1E_2D3C, 2'b00, 0, 1, "R2 R3 R5 split pattern a");
    drive(32'hF0E1_D2C3, 2'b00, 0, 1, "R9 load pattern b");
    drive(32'h5A5A_A5A5, 2'b00, 0, 0, "R9 hold");
    drive(32'h8888_7777, 2'b00, 0, 0, "R3 pattern c");
    // disabled configuration port ignores shifts (R1)
    load_cfg(0);
    drive(32'h8888_7777, 2'b00, 0, 0, "R1 cfg_en low ignored");
    // cascade mode, bit 3 toggled (R4)
    s = 4'h0; rv = 8'h3C;
    load_cfg(1);
    do_reset();
    drive(32'h0000_0000, 2'b00, 0, 0, "R10 second vector");
    drive(32'h3132_3334, 2'b00, 0, 1, "R4 cascade");
    drive(32'h393A_3B3C, 2'b00, 0, 1, "R4 bit3 ignored");
    drive(32'hC5D6_E7F0, 2'b00, 0, 1, "R4 cascade b");
    // reset wins over reg_ce (R10)
    do_reset();
    drive(32'hC5D6_E7F0, 2'b00, 0, 0, "R10 reset over ce");
    // wide muxes (R6, R7)
    s = 4'hF; m7 = 1; m8 = 1;
    load_cfg(1);
    for (int h = 0; h < 4; h++) begin
      drive(32'h1B2C_3D4E, 2'(h), 0, 0, "R6 R7 muxes");
      drive(32'hE4D3_C2B1, 2'(h), 0, 0, "R6 R7 muxes");
    end
    m7 = 0;
    load_cfg(1);
    drive(32'h1B2C_3D4E, 2'b10, 0, 0, "R7 A disabled");
    drive(32'h1B2C_3D4E, 2'b00, 0, 0, "R7 A disabled low");
    // adder, carry overrides muxes (R8, R11)
    for (int k = 0; k < 4; k++) t[k] = 32'h6666_8888;
    m7 = 1; m8 = 1; cc = 1;
    load_cfg(1);
    drive(add_in(4'd15, 4'd1),  2'b11, 0, 0, "R8 R11 15+1",  1, 5'd16);
    drive(add_in(4'd15, 4'd15), 2'b01, 1, 0, "R8 R11 15+15+1", 1, 5'd31);
    drive(add_in(4'd6,  4'd9),  2'b10, 0, 0, "R8 R11 6+9",   1, 5'd15);
    drive(add_in(4'd0,  4'd0),  2'b00, 1, 0, "R8 R11 0+0+1", 1, 5'd1);
    drive(add_in(4'd7,  4'd5),  2'b11, 0, 1, "R11 7+5",      1, 5'd12);
    drive(add_in(4'd7,  4'd5),  2'b11, 0, 0, "R9 reg of sum");
    wait (q.size() == 0);
    @(negedge clk); #1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule